// File: doc/BRIEF.md
# Gapped-Clock Serial Cell Interface

This block links a byte-oriented core to a network framer over two bit-serial lanes, one per direction. Each lane has one data wire and one clock wire. The block drives both clocks itself from its reference clock. While running, a lane clock is high for one reference cycle and low for the next, so one bit moves every two reference cycles.

On the inbound lane the clock runs only while the downstream byte store reports at least two free bytes. Inbound data is sampled only on rising lane-clock edges. Every reference cycle in which the block holds the clock low adds to a gap count. A gap up to the programmable threshold is plain flow control. A longer gap is a byte-alignment mark: the bit that follows is taken as the most significant bit of a new byte. The far end follows the same rule, so both sides restart at a byte boundary.

On the outbound lane the block takes bytes through a valid/ready handshake and sends them MSB first. The clock runs only while a byte is in flight and stops only between bytes. Bytes are not parsed at all, so idle-cell fill passes through like any other traffic.

Top module: `gapclk_serial_if`

## Requirements
- R1: While rst_ni is low, rx_sclk_o and tx_sclk_o are low, rx_valid_o is low and tx_ready_o is high. Both bit counters are cleared, so the first inbound and the first outbound bit after reset is the MSB of a byte.
- R2: rx_sclk_o is high for exactly one reference cycle at a time. It rises only at a reference edge where rx_space_i was at least 2. Otherwise it is held low.
- R3: rx_sdata_i is captured at the reference edge where rx_sclk_o goes from low to high, and at no other edge. Bits are assembled MSB first.
- R4: When the eighth bit of a byte is captured, rx_valid_o is high for that one cycle and rx_data_o holds the byte, in the same cycle in which rx_sclk_o is high.
- R5: The gap is the number of reference cycles the inbound clock is held low beyond its normal single low cycle. When the gap is at or below gap_thresh_i, assembly continues with the next bit of the current byte.
- R6: When the gap exceeds gap_thresh_i, any partly assembled byte is discarded and the next captured bit is the MSB of a new byte. With a threshold of 0, any held cycle triggers this.
- R7: The gap count saturates at 65535 and does not wrap. A gap of 70000 cycles therefore still exceeds a threshold of 65534.
- R8: Every byte value is delivered unchanged. This includes an idle cell (header 00 00 00 01 52 followed by 48 bytes of 6A).
- R9: A byte is taken at a reference edge where tx_valid_i and tx_ready_o are both high. It is sent MSB first. tx_sdata_o changes only at the edge where tx_sclk_o falls, so it is stable while tx_sclk_o is high.
- R10: tx_sclk_o gives exactly 8 one-cycle high pulses per byte taken, and none when no byte is in flight. It is held low for more than one cycle only between bytes. Back-to-back bytes run gap-free: 4 bytes produce 32 rising edges spanning 62 reference cycles from first to last.
- R11: tx_ready_o is high when no outbound bit is left to send. It is also high during the high phase of the last bit of a byte. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gap_thresh_i | input | 16 | Gap threshold in reference cycles |
| rx_sclk_o | output | 1 | Inbound lane clock, driven to the framer |
| rx_sdata_i | input | 1 | Inbound serial data |
| rx_space_i | input | 4 | Free bytes in the downstream byte store |
| rx_valid_o | output | 1 | Inbound byte strobe |
| rx_data_o | output | 8 | Inbound byte |
| tx_sclk_o | output | 1 | Outbound lane clock, driven to the framer |
| tx_sdata_o | output | 1 | Outbound serial data |
| tx_valid_i | input | 1 | Outbound byte offered |
| tx_ready_o | output | 1 | Outbound byte can be taken |
| tx_data_i | input | 8 | Outbound byte |

## Verification
The inbound checks assume the following:
- rx_space_i is synchronous to the reference clock and does not overstate the free space.
- The far end puts a new bit on rx_sdata_i after each falling lane-clock edge and applies the same gap rule.
- tx_data_i stays put while tx_valid_i is high.

The bench changes rx_space_i and gap_thresh_i only between reference edges. Its far-end model counts held cycles exactly as the rule defines them and realigns its own byte pointer when the count passes the threshold. Its outbound source holds each byte until the handshake completes and inserts random idle stretches between bytes.

// File: rtl/gapclk_pkg.sv
package gapclk_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } sclk_ph_e;
endpackage

// File: rtl/gapclk_gap_timer.sv
module gapclk_gap_timer #(
  parameter int GAP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             clear_i,
  input  logic [GAP_W-1:0] thresh_i,
  output logic             realign_o
);
  localparam logic [GAP_W-1:0] GapMax = '1;

  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (hold_i && cnt_q != GapMax) begin
      cnt_q <= cnt_q + GAP_W'(1);
    end
  end

  assign realign_o = cnt_q > thresh_i;

  p_gap_saturates_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !clear_i && cnt_q == GapMax) |=> cnt_q == GapMax)
    else $error("gap count wrapped");

  p_gap_cleared_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0)
    else $error("gap count not cleared on rise");
endmodule

// File: rtl/gapclk_rx_deser.sv
module gapclk_rx_deser
  import gapclk_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int GAP_W     = 16,
  parameter int SPACE_W   = 4,
  parameter int SPACE_MIN = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [GAP_W-1:0]   gap_thresh_i,
  input  logic               rx_sdata_i,
  input  logic [SPACE_W-1:0] rx_space_i,
  output logic               rx_sclk_o,
  output logic               rx_valid_o,
  output logic [BYTE_W-1:0]  rx_data_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  sclk_ph_e          ph_q;
  logic [CNT_W-1:0]  bit_q;
  logic [BYTE_W-2:0] sh_q;
  logic              room, rise, hold, realign;

  assign room = rx_space_i >= SPACE_W'(SPACE_MIN);
  assign rise = (ph_q == PH_LOW) && room;
  assign hold = (ph_q == PH_LOW) && !room;

  gapclk_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (hold),
    .clear_i  (rise),
    .thresh_i (gap_thresh_i),
    .realign_o(realign)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_LOW;
    end else if (ph_q == PH_HIGH) begin
      ph_q <= PH_LOW;
    end else if (room) begin
      ph_q <= PH_HIGH;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q      <= '0;
      sh_q       <= '0;
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
    end else begin
      rx_valid_o <= 1'b0;
      if (rise) begin
        if (realign) begin
          // long gap: drop partial byte, this bit is the MSB
          sh_q  <= {{(BYTE_W-2){1'b0}}, rx_sdata_i};
          bit_q <= CNT_W'(1);
        end else if (bit_q == CNT_W'(BYTE_W-1)) begin
          rx_data_o  <= {sh_q, rx_sdata_i};
          rx_valid_o <= 1'b1;
          bit_q      <= '0;
        end else begin
          sh_q  <= {sh_q[BYTE_W-3:0], rx_sdata_i};
          bit_q <= bit_q + CNT_W'(1);
        end
      end
    end
  end

  assign rx_sclk_o = (ph_q == PH_HIGH);

  p_rx_single_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_sclk_o |=> !rx_sclk_o)
    else $error("inbound clock high too long");

  p_rx_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_sclk_o) |-> $past(rx_space_i) >= SPACE_W'(SPACE_MIN))
    else $error("inbound clock ran with no room");

  p_rx_strobe_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> rx_sclk_o)
    else $error("byte strobe outside high phase");
endmodule

// File: rtl/gapclk_tx_ser.sv
module gapclk_tx_ser
  import gapclk_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_valid_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              tx_sclk_o,
  output logic              tx_sdata_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  sclk_ph_e          ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              take;

  assign tx_ready_o = (cnt_q == '0) || (cnt_q == CNT_W'(1) && ph_q == PH_HIGH);
  assign take       = tx_valid_i && tx_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_LOW;
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (ph_q == PH_HIGH) begin
      ph_q <= PH_LOW;
      if (cnt_q == CNT_W'(1)) begin
        if (take) begin
          sh_q  <= tx_data_i;
          cnt_q <= CNT_W'(BYTE_W);
        end else begin
          cnt_q <= '0;
        end
      end else begin
        sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end else if (cnt_q != '0) begin
      ph_q <= PH_HIGH;
    end else if (take) begin
      sh_q  <= tx_data_i;
      cnt_q <= CNT_W'(BYTE_W);
    end
  end

  assign tx_sclk_o  = (ph_q == PH_HIGH);
  assign tx_sdata_o = sh_q[BYTE_W-1];

  p_tx_single_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_sclk_o |=> !tx_sclk_o)
    else $error("outbound clock high too long");

  p_tx_no_idle_clock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_sclk_o |-> cnt_q != '0)
    else $error("outbound clock with no byte");

  p_tx_boundary_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_sclk_o && !$past(tx_sclk_o)) |-> (cnt_q == '0 || cnt_q == CNT_W'(BYTE_W)))
    else $error("outbound clock stopped inside a byte");

  p_tx_data_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_sclk_o |-> $stable(tx_sdata_o))
    else $error("outbound data moved at rising edge");
endmodule

// File: rtl/gapclk_serial_if.sv
module gapclk_serial_if #(
  parameter int BYTE_W    = 8,
  parameter int GAP_W     = 16,
  parameter int SPACE_W   = 4,
  parameter int SPACE_MIN = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [GAP_W-1:0]   gap_thresh_i,
  output logic               rx_sclk_o,
  input  logic               rx_sdata_i,
  input  logic [SPACE_W-1:0] rx_space_i,
  output logic               rx_valid_o,
  output logic [BYTE_W-1:0]  rx_data_o,
  output logic               tx_sclk_o,
  output logic               tx_sdata_o,
  input  logic               tx_valid_i,
  output logic               tx_ready_o,
  input  logic [BYTE_W-1:0]  tx_data_i
);
  gapclk_rx_deser #(
    .BYTE_W   (BYTE_W),
    .GAP_W    (GAP_W),
    .SPACE_W  (SPACE_W),
    .SPACE_MIN(SPACE_MIN)
  ) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gap_thresh_i(gap_thresh_i),
    .rx_sdata_i  (rx_sdata_i),
    .rx_space_i  (rx_space_i),
    .rx_sclk_o   (rx_sclk_o),
    .rx_valid_o  (rx_valid_o),
    .rx_data_o   (rx_data_o)
  );

  gapclk_tx_ser #(.BYTE_W(BYTE_W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_valid_i(tx_valid_i),
    .tx_data_i (tx_data_i),
    .tx_ready_o(tx_ready_o),
    .tx_sclk_o (tx_sclk_o),
    .tx_sdata_o(tx_sdata_o)
  );

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!rx_sclk_o && !tx_sclk_o && !rx_valid_o))
    else $error("outputs active in reset");
endmodule

// File: tb/gapclk_serial_if_test.sv
`timescale 1ns/1ps
module gapclk_serial_if_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] thresh;
  logic        rx_sclk, rx_sdata, rx_valid;
  logic [3:0]  space;
  logic [7:0]  rx_data;
  logic        tx_sclk, tx_sdata, tx_valid, tx_ready;
  logic [7:0]  tx_data;

  always #2 clk = ~clk;

  gapclk_serial_if uut (
    .clk_i(clk), .rst_ni(rst_ni), .gap_thresh_i(thresh),
    .rx_sclk_o(rx_sclk), .rx_sdata_i(rx_sdata), .rx_space_i(space),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .tx_sclk_o(tx_sclk), .tx_sdata_o(tx_sdata), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .tx_data_i(tx_data)
  );

  int    checks = 0, errors = 0;
  string tag = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int sat_inc(input int g);
    return (g >= 65535) ? 65535 : g + 1;
  endfunction

  // far-end inbound model
  logic [7:0] rx_src[$];
  logic [7:0] rx_exp[$];
  logic [7:0] cur;
  int bitpos, gap, realigns = 0, rx_got = 0, prev_space;
  bit prev_low, prev_high;

  function automatic logic [7:0] next_rx();
    if (rx_src.size() > 0) return rx_src.pop_front();
    return 8'($urandom);
  endfunction

  task automatic rx_far();
    logic [7:0] e;
    cur = next_rx(); bitpos = 0; gap = 0; prev_low = 0; prev_high = 0;
    prev_space = 15;
    forever begin
      @(negedge clk); #1;
      if (!rst_ni) begin
        gap = 0; prev_low = 0; prev_high = 0; bitpos = 0;
        rx_sdata = cur[7];
        prev_space = space;
        continue;
      end
      if (rx_sclk) begin
        if (prev_space < 2) chk(0, "R2", "clock rose with space", prev_space, 2);
        if (prev_high) chk(0, "R2", "clock high two cycles", 2, 1);
        bitpos++;
        if (bitpos == 8) begin
          rx_exp.push_back(cur);
          cur = next_rx();
          bitpos = 0;
        end
        gap = 0; prev_low = 0; prev_high = 1;
      end else begin
        if (prev_low) gap = sat_inc(gap);
        prev_low = 1; prev_high = 0;
        if (gap > int'(thresh) && bitpos != 0) begin
          realigns++;
          cur = next_rx();
          bitpos = 0;
        end
      end
      if (rx_valid) begin
        chk(rx_sclk, "R4", "strobe outside high phase", rx_sclk, 1);
        if (rx_exp.size() == 0) chk(0, tag, "unexpected rx byte", rx_data, 0);
        else begin
          e = rx_exp.pop_front();
          chk(rx_data == e, tag, "rx byte", rx_data, e);
          rx_got++;
        end
      end
      rx_sdata = cur[7-bitpos];
      prev_space = space;
    end
  endtask

  // outbound source and monitor
  logic [7:0] tx_q[$];
  logic [7:0] tx_exp[$];
  logic [7:0] tx_asm;
  int  rem = 0, tx_nbits = 0, tx_rises = 0, tx_wait = 0, cyc = 0;
  int  burst_base = -1000, t0 = 0, t1 = 0;
  bit  tx_taken = 0, tx_gaps = 1, tx_prev_low = 0;

  task automatic tx_src();
    logic [7:0] e;
    forever begin
      @(negedge clk);
      cyc++;
      if (tx_taken) begin tx_valid = 1'b0; tx_taken = 0; end
      if (rst_ni && !tx_valid && tx_q.size() > 0) begin
        if (tx_wait > 0) tx_wait--;
        else begin
          tx_valid = 1'b1;
          tx_data  = tx_q.pop_front();
          tx_wait  = tx_gaps ? $urandom_range(0, 12) : 0;
        end
      end
      #1;
      if (rst_ni) begin
        if (tx_sclk) begin
          if (rem == 0) chk(0, "R10", "clock with no byte", tx_rises, 0);
          else rem--;
          if (tx_rises == burst_base) t0 = cyc;
          if (tx_rises == burst_base + 31) t1 = cyc;
          tx_rises++;
          tx_asm = {tx_asm[6:0], tx_sdata};
          tx_nbits++;
          if (tx_nbits % 8 == 0) begin
            if (tx_exp.size() == 0) chk(0, "R9", "byte with none sent", tx_asm, 0);
            else begin
              e = tx_exp.pop_front();
              chk(tx_asm == e, "R9", "tx byte", tx_asm, e);
            end
          end
          tx_prev_low = 0;
        end else begin
          if (tx_prev_low && tx_nbits % 8 != 0)
            chk(0, "R10", "clock held inside byte", tx_nbits % 8, 0);
          tx_prev_low = 1;
        end
        chk(tx_ready == (rem == 0), "R11", "ready", tx_ready, rem == 0);
        if (tx_valid && tx_ready) begin
          tx_exp.push_back(tx_data);
          rem += 8;
          tx_taken = 1;
        end
      end
    end
  endtask

  task automatic push_tx(input int n);
    for (int i = 0; i < n; i++) tx_q.push_back(8'($urandom));
  endtask

  task automatic random_holds(input int n, input int maxhold);
    for (int i = 0; i < n; i++) begin
      space = 4'($urandom_range(0, 1));
      repeat ($urandom_range(1, maxhold)) @(negedge clk);
      space = 4'($urandom_range(2, 15));
      repeat ($urandom_range(1, 20)) @(negedge clk);
    end
    space = 4'd15;
  endtask

  initial begin
    int r0, g0;
    void'($urandom(32'h1d5e_a7c3));
    thresh = 16'hffff; space = 4'd15; tx_valid = 1'b0; tx_data = '0; rx_sdata = 1'b0;
    fork
      rx_far();
      tx_src();
    join_none
    repeat (4) @(negedge clk);
    #1;
    chk(!rx_sclk, "R1", "rx clock in reset", rx_sclk, 0);
    chk(!tx_sclk, "R1", "tx clock in reset", tx_sclk, 0);
    chk(!rx_valid, "R1", "rx strobe in reset", rx_valid, 0);
    chk(tx_ready, "R1", "tx ready in reset", tx_ready, 1);
    @(negedge clk);
    rst_ni = 1'b1;

    // free-running traffic
    tag = "R3"; thresh = 16'd3;
    push_tx(12);
    repeat (400) @(negedge clk);
    chk(rx_got >= 20, "R3", "bytes delivered", rx_got, 20);

    // short holds: plain flow control
    tag = "R5"; thresh = 16'd8; r0 = realigns;
    push_tx(10);
    random_holds(60, 4);
    repeat (40) @(negedge clk);
    chk(realigns == r0, "R5", "short gaps realigned", realigns - r0, 0);

    // threshold 0: every hold realigns
    tag = "R6"; thresh = 16'd0; r0 = realigns;
    push_tx(10);
    random_holds(40, 5);
    repeat (40) @(negedge clk);
    chk(realigns > r0, "R6", "realign events", realigns - r0, 1);
    thresh = 16'd5;
    while (bitpos != 4) @(negedge clk);
    r0 = realigns;
    space = 4'd1;
    repeat (10) @(negedge clk);
    space = 4'd15;
    repeat (60) @(negedge clk);
    chk(realigns == r0 + 1, "R6", "directed realign", realigns - r0, 1);

    // idle cell passes through
    tag = "R8"; thresh = 16'd3;
    while (bitpos != 0) @(negedge clk);
    g0 = rx_got + rx_exp.size() + 1;
    rx_src.push_back(8'h00); rx_src.push_back(8'h00);
    rx_src.push_back(8'h00); rx_src.push_back(8'h01);
    rx_src.push_back(8'h52);
    for (int i = 0; i < 48; i++) rx_src.push_back(8'h6A);
    repeat (53 * 16 + 60) @(negedge clk);
    chk(rx_got >= g0 + 53, "R8", "idle cell bytes delivered", rx_got - g0, 53);

    // saturation: 70000-cycle gap beats threshold 65534
    tag = "R7"; thresh = 16'd65534;
    while (bitpos != 3) @(negedge clk);
    r0 = realigns;
    space = 4'd0;
    repeat (70000) @(negedge clk);
    space = 4'd15;
    repeat (200) @(negedge clk);
    chk(realigns == r0 + 1, "R7", "saturated gap realign", realigns - r0, 1);

    // back-to-back outbound burst
    tag = "R10";
    while (tx_q.size() != 0 || tx_valid || rem != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    tx_gaps = 0; tx_wait = 0;
    r0 = tx_rises;
    burst_base = tx_rises;
    push_tx(4);
    while (tx_rises < r0 + 32) @(negedge clk);
    chk(t1 - t0 == 62, "R10", "burst span", t1 - t0, 62);
    repeat (60) @(negedge clk);
    chk(tx_rises == r0 + 32, "R10", "idle clock pulses", tx_rises - r0, 32);
    chk(tx_ready, "R11", "ready when idle", tx_ready, 1);

    repeat (50) @(negedge clk);
    chk(rx_exp.size() == 0, "R4", "rx bytes outstanding", rx_exp.size(), 0);
    chk(tx_exp.size() == 0, "R9", "tx bytes outstanding", tx_exp.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog", "run did not finish", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule